// File: doc/BRIEF.md
# Low-Transition Single-Input-Change Test Pattern Generator

This block produces stimulus words for built-in self-test. Each word changes in only one bit from the word before it, which keeps switching activity in the logic under test low. A binary step counter of `CNT_W` bits starts from zero and wraps after `2^CNT_W` states. Its value is turned into a reflected Gray code.

A maximal-length shift register of `SEED_W` bits supplies a seed. The seed moves on only at the enabled edge where the counter reads all zeros. An all-zero detector gates the seed register's clock enable. The output word is the seed XORed with the Gray code, and the Gray code is zero-padded into the low bits.

Inside one seed period the output walks a Gray sequence around the seed, one bit at a time. At each counter wrap a fresh pseudo-random seed moves the walk to a new place in the vector space. A run enable freezes the whole generator. A valid flag marks the words produced by an enabled step, and a one-cycle flag marks the word where a new seed first appears.

Top module: `sic_pattern_gen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears its state. After that edge, `pattern` equals the reset seed `SEED_INIT` (default 8'h01), because the counter is zero and its Gray code is zero. `pattern_valid` and `seed_change` are both 0.
- R2: Each enabled edge advances the step counter by one, modulo `2^CNT_W`. The counter starts from 0 after reset.
- R3: `pattern` always equals seed XOR G. G is `c ^ (c >> 1)` for the counter value `c`. G sits in bits `[CNT_W-1:0]`, and the upper bits are zero.
- R4: The seed changes only at an enabled edge where the counter is all zeros before that edge. At every other edge the seed holds.
- R5: Suppose two consecutive valid words are produced without a seed change between them. Those two words differ in exactly one bit.
- R6: A seed step shifts the register toward its MSB. The new bit 0 is the XOR of bits 7, 5, 4 and 3, which is the default tap mask 8'hB8 for x^8+x^6+x^5+x^4+1. The seed is never zero, and it visits 255 distinct values before repeating.
- R7: When `run_en` is low at an edge, the counter and the seed hold. As a result, `pattern` is unchanged in the next cycle.
- R8: `seed_change` is 1 exactly in the cycle that follows an edge where the seed advanced. Otherwise it is 0.
- R9: `pattern_valid` is 1 exactly in the cycle that follows an edge where `run_en` was high and the block was not in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the counter, the Gray stage and the seed register |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Step enable; low freezes all state |
| pattern | output | SEED_W | Current test word: seed XOR padded Gray code |
| pattern_valid | output | 1 | The current word comes from an enabled step |
| seed_change | output | 1 | The current word is the first one under a new seed |

## Verification
An uninterrupted run longer than the full seed period is compared against a behavioural model. Across 255 seed changes, it separates a correct tap set and zero-detect gate from a wrong tap, a short sequence or a seed that steps too often. A run with a sparse, irregular enable is also used, including holds placed on the all-zero counter value. It tells a seed and counter that freeze from ones that drift while the enable is low, and it checks that the valid flag drops. A reset in the middle of a run shows that all state returns to its start values. The one-bit-distance rule is also checked on every pair of valid words.

// File: rtl/sic_pkg.sv
// Package sic_pkg: default sizing and polynomial constants shared by the
// pattern generator and its checker. Assumes the seed width is at least the
// counter width.
package sic_pkg;
    localparam int          DEF_CNT_W    = 4;
    localparam int          DEF_SEED_W   = 8;
    // x^8 + x^6 + x^5 + x^4 + 1 : feedback from bits 7,5,4,3
    localparam logic [7:0]  DEF_TAP_MASK = 8'hB8;
    localparam logic [7:0]  DEF_SEED     = 8'h01;
endpackage

// File: rtl/sic_step_counter.sv
// Module sic_step_counter: binary step counter with reflected Gray output and
// an all-zero (NOR) detect. Assumes step is qualified by the caller; the
// counter wraps naturally at 2^CNT_W.
module sic_step_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] gray,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt_q;

    // Advance the counter on each qualified step, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Gray conversion and all-zero detect of the held count.
    always_comb begin
        gray    = cnt_q ^ (cnt_q >> 1);
        at_zero = ~(|cnt_q);
    end

    assign count = cnt_q;
endmodule

// File: rtl/sic_seed_lfsr.sv
// Module sic_seed_lfsr: Fibonacci shift register that shifts toward the MSB
// and feeds the XOR of the masked taps into bit 0. Assumes TAP_MASK is a
// primitive polynomial and SEED_INIT is nonzero, so the zero state is never
// reached.
module sic_seed_lfsr #(
    parameter int                SEED_W    = 8,
    parameter logic [SEED_W-1:0] TAP_MASK  = 8'hB8,
    parameter logic [SEED_W-1:0] SEED_INIT = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [SEED_W-1:0] seed
);
    logic [SEED_W-1:0] seed_q;
    logic              feedback;

    // Parity of the tapped stages forms the new first-stage bit.
    always_comb begin
        feedback = ^(seed_q & TAP_MASK);
    end

    // Shift once per advance request, load the start seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= SEED_INIT;
        end else if (advance) begin
            seed_q <= {seed_q[SEED_W-2:0], feedback};
        end
    end

    assign seed = seed_q;
endmodule

// File: rtl/sic_xor_mixer.sv
// Module sic_xor_mixer: bitwise XOR of the seed with the Gray code, which is
// zero-padded into the low CNT_W bits. Purely combinational. Assumes
// CNT_W <= SEED_W.
module sic_xor_mixer #(
    parameter int CNT_W  = 4,
    parameter int SEED_W = 8
) (
    input  logic [SEED_W-1:0] seed,
    input  logic [CNT_W-1:0]  gray,
    output logic [SEED_W-1:0] mixed
);
    localparam int PAD_W = SEED_W - CNT_W;

    // Low lanes: seed bit flipped by the matching Gray bit.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mix
        assign mixed[i] = seed[i] ^ gray[i];
    end

    // Upper lanes: seed passes through untouched.
    if (PAD_W > 0) begin : g_pad
        assign mixed[SEED_W-1:CNT_W] = seed[SEED_W-1:CNT_W];
    end
endmodule

// File: rtl/sic_pattern_gen.sv
// Module sic_pattern_gen: top of the low-transition pattern generator.
// Wires the step counter, the zero-gated seed register and the XOR mixer,
// and registers the valid and seed-change flags. Assumes a synchronous
// active-low reset and CNT_W <= SEED_W.
module sic_pattern_gen
    import sic_pkg::*;
#(
    parameter int                CNT_W     = DEF_CNT_W,
    parameter int                SEED_W    = DEF_SEED_W,
    parameter logic [SEED_W-1:0] TAP_MASK  = DEF_TAP_MASK,
    parameter logic [SEED_W-1:0] SEED_INIT = DEF_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    output logic [SEED_W-1:0] pattern,
    output logic              pattern_valid,
    output logic              seed_change
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  gray_w;
    logic              cnt_zero;
    logic              seed_adv;
    logic [SEED_W-1:0] seed_q;
    logic              valid_q;
    logic              chg_q;

    // Seed moves only on an enabled step taken from the all-zero count.
    always_comb begin
        seed_adv = run_en & cnt_zero;
    end

    sic_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (run_en),
        .count   (cnt_q),
        .gray    (gray_w),
        .at_zero (cnt_zero)
    );

    sic_seed_lfsr #(
        .SEED_W    (SEED_W),
        .TAP_MASK  (TAP_MASK),
        .SEED_INIT (SEED_INIT)
    ) u_seed (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (seed_adv),
        .seed    (seed_q)
    );

    sic_xor_mixer #(.CNT_W(CNT_W), .SEED_W(SEED_W)) u_mix (
        .seed  (seed_q),
        .gray  (gray_w),
        .mixed (pattern)
    );

    // Flag registers: valid after an enabled step, change after a seed step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            chg_q   <= 1'b0;
        end else begin
            valid_q <= run_en;
            chg_q   <= seed_adv;
        end
    end

    assign pattern_valid = valid_q;
    assign seed_change   = chg_q;
endmodule

// File: rtl/sic_pattern_gen_chk.sv
// Module sic_pattern_gen_chk: property checker bound into sic_pattern_gen.
// Observes the ports plus the counter, the seed and the zero detect.
module sic_pattern_gen_chk #(
    parameter int CNT_W  = 4,
    parameter int SEED_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [SEED_W-1:0] pattern,
    input logic              pattern_valid,
    input logic              seed_change,
    input logic [CNT_W-1:0]  cnt,
    input logic [SEED_W-1:0] seed,
    input logic              cnt_zero
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R4
    seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && cnt_zero) |=> $stable(seed));

    // R5
    one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && run_en && !cnt_zero) |=> ($countones(pattern ^ $past(pattern)) == 1));

    // R6
    seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed != '0);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!pattern_valid && $stable(pattern) && $stable(cnt)));

    // R8
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_change |=> !seed_change);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> pattern_valid);
endmodule

bind sic_pattern_gen sic_pattern_gen_chk #(.CNT_W(CNT_W), .SEED_W(SEED_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_en        (run_en),
    .pattern       (pattern),
    .pattern_valid (pattern_valid),
    .seed_change   (seed_change),
    .cnt           (cnt_q),
    .seed          (seed_q),
    .cnt_zero      (cnt_zero)
);

// File: tb/tb_sic_pattern_gen.sv
module tb_sic_pattern_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 4;
    localparam int SW = 8;
    localparam int CPERIOD = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [SW-1:0] pattern;
    logic          pattern_valid;
    logic          seed_change;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int  m_cnt, m_seed;
    bit  m_valid, m_sc;
    int  prev_pat;
    bit  prev_valid;
    bit  collect;
    bit  seen [256];
    int  n_seeds, first_seed;

    always #(CLK_PERIOD/2) clk = ~clk;

    sic_pattern_gen dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .pattern(pattern), .pattern_valid(pattern_valid), .seed_change(seed_change)
    );

    function automatic int next_seed(int s);
        int fb;
        fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
        return ((s * 2) % 256) + fb;
    endfunction

    function automatic int gray_of(int c);
        return c ^ (c / 2);
    endfunction

    function automatic int ones(int v);
        int n = 0;
        for (int i = 0; i < 32; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        int p;
        p = int'(pattern);
        chk(p == (m_seed ^ gray_of(m_cnt)), "R3 R2 R4 R6 pattern", p, m_seed ^ gray_of(m_cnt));
        chk(pattern_valid == m_valid, "R9 R7 pattern_valid", int'(pattern_valid), int'(m_valid));
        chk(seed_change == m_sc, "R8 seed_change", int'(seed_change), int'(m_sc));
        if (pattern_valid && prev_valid && !seed_change)
            chk(ones(p ^ prev_pat) == 1, "R5 hamming distance", ones(p ^ prev_pat), 1);
        if (!pattern_valid && prev_valid == 0 && !m_valid)
            chk(p == prev_pat || !rst_n, "R7 hold", p, prev_pat);
        if (collect && seed_change) begin
            int s;
            s = p ^ 1;
            if (n_seeds == 0) first_seed = s;
            if (n_seeds < 255) begin
                chk(s != 0 && !seen[s], "R6 distinct nonzero seed", s, 0);
                seen[s] = 1;
            end else if (n_seeds == 255) begin
                chk(s == first_seed, "R6 seed period 255", s, first_seed);
            end
            n_seeds++;
        end
        prev_pat = p;
        prev_valid = pattern_valid;
    endtask

    task automatic cycle(bit en);
        run_en = en;
        @(posedge clk);
        if (en) begin
            m_sc = (m_cnt == 0);
            if (m_cnt == 0) m_seed = next_seed(m_seed);
            m_cnt = (m_cnt + 1) % CPERIOD;
            m_valid = 1;
        end else begin
            m_sc = 0;
            m_valid = 0;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        run_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_cnt = 0; m_seed = 1; m_valid = 0; m_sc = 0;
        chk(pattern == 8'h01, "R1 reset pattern", int'(pattern), 1);
        chk(!pattern_valid, "R1 reset valid", int'(pattern_valid), 0);
        chk(!seed_change, "R1 reset seed_change", int'(seed_change), 0);
        prev_pat = int'(pattern);
        prev_valid = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        collect = 0; n_seeds = 0; first_seed = 0;
        @(negedge clk);
        do_reset();
        // continuous run across several wraps
        for (int i = 0; i < 40; i++) cycle(1'b1);
        // irregular enable, including holds at the all-zero count
        for (int i = 0; i < 90; i++) cycle((i % 3 != 0) && (i % 7 != 5));
        while (m_cnt != 0) cycle(1'b1);
        for (int i = 0; i < 4; i++) cycle(1'b0);
        cycle(1'b1);
        // long run spanning the full seed period
        collect = 1;
        for (int i = 0; i < 255 * CPERIOD + 40; i++) cycle(1'b1);
        collect = 0;
        chk(n_seeds >= 256, "R6 seeds observed", n_seeds, 256);
        // reset mid-run
        for (int i = 0; i < 5; i++) cycle(1'b1);
        do_reset();
        for (int i = 0; i < 20; i++) cycle(1'b1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule